// File: doc/BRIEF.md
# Dual-Modulus Programmable Frequency Divider

This block divides a fast input clock by a programmable ratio N of up to 17 bits, for use as the feedback divider in a frequency synthesiser loop. N is split into a high part M (13 bits) and a low part A (4 bits), so N = 16·M + A. Each output cycle is made of M sub-cycles. The first A sub-cycles last 17 input ticks and the remaining M−A last 16 ticks. An optional divide-by-two stage in front of the counters doubles the overall ratio. It is modelled in the same clock domain as a tick enable that fires on every second clock.

The controller presents a ratio and a prescaler select with a one-clock load pulse. The block holds the request and applies it only when the M counter reloads, which keeps tuning steps free of glitches. A one-clock strobe marks each reload. The divided output goes to the phase comparator, and a half-rate copy of it is provided for routing to a test port.

Top module: `mnd_divider`

## Requirements
- R1: During and after reset, `fpd`, `fpd_half` and `strobe` are low. The divider starts with ratio 240 and the prescaler off, so the first `strobe` appears 240 clocks after reset is released.
- R2: The ratio is taken as M = ratio[16:4] and A = ratio[3:0]. With `pe` = 0, rising edges of `fpd` are exactly N = 16·M + A clocks apart, for any N from 240 up to 131071.
- R3: With `pe` = 1, rising edges of `fpd` are exactly 2·N clocks apart, which covers 480 to 262142.
- R4: `fpd` stays high for the first sub-cycle of each output cycle. That is 17 ticks when A ≠ 0 and 16 ticks when A = 0, where a tick is one clock with `pe` = 0 and two clocks with `pe` = 1.
- R5: `strobe` is high for exactly one clock per output cycle. It rises in the same clock as `fpd`, and `fpd` never rises without it.
- R6: `fpd_half` toggles in the clock where `strobe` is high and holds at all other times, so its period is twice that of `fpd`.
- R7: A request given by `load` = 1 (with `ratio` and `pe`) does not change the output cycle in progress. The cycle that starts at the next `strobe` uses the new ratio and the new prescaler setting.
- R8: When several requests arrive before a reload, only the last one is applied.
- R9: A request with M < 2 or M < A is discarded, and the previously active ratio and `pe` continue unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio | input | 17 | Requested division ratio N (M in bits 16:4, A in bits 3:0) |
| pe | input | 1 | Requested prescaler select; 1 inserts the divide-by-two stage |
| load | input | 1 | One-clock pulse that submits `ratio` and `pe` |
| fpd | output | 1 | Divided output, high during the first sub-cycle of each output cycle |
| fpd_half | output | 1 | `fpd` divided by two, for test routing |
| strobe | output | 1 | One-clock pulse at each reload of the M counter |

## Verification
The bench uses the default parameters: a 13-bit M field, a 4-bit A field, the prescaler stage present and a reset ratio of 240. With these widths the full direct range is reachable, including the 131071 ceiling, along with 16- and 17-tick first sub-cycles and M-versus-A rejection at realistic field sizes. With the prescaler on, ratios are kept small so the run stays short. The doubling and the switch between the two prescaler settings are still exercised at both ends of the low range.

// File: rtl/mnd_pkg.sv
package mnd_pkg;

  // Default field widths of the ratio word: N = 2**A_W * M + A
  localparam int unsigned DEF_M_W       = 13;
  localparam int unsigned DEF_A_W       = 4;
  // Ratio active after reset
  localparam int unsigned DEF_RST_RATIO = 240;
  // Smallest M accepted (keeps the first sub-cycle apart from the reload)
  localparam int unsigned MIN_M         = 2;

endpackage

// File: rtl/mnd_tick_gen.sv
module mnd_tick_gen #(
  parameter bit HAS_PRESCALE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic pe_act,
  input  logic realign,
  output logic tick
);

  generate
    if (HAS_PRESCALE) begin : g_div2
      logic ph;
      // Phase restarts at every reload so a newly enabled /2 stage
      // gives exactly two clocks per tick from the first tick on.
      always_ff @(posedge clk) begin
        if (rst)          ph <= 1'b0;
        else if (realign) ph <= 1'b0;
        else              ph <= ~ph;
      end
      assign tick = ~pe_act | ph;
    end else begin : g_direct
      wire unused_tick_in = clk ^ rst ^ pe_act ^ realign;
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/mnd_ratio_hold.sv
module mnd_ratio_hold #(
  parameter int unsigned M_W       = mnd_pkg::DEF_M_W,
  parameter int unsigned A_W       = mnd_pkg::DEF_A_W,
  parameter int unsigned RST_RATIO = mnd_pkg::DEF_RST_RATIO,
  localparam int unsigned N_W      = M_W + A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [N_W-1:0] ratio,
  input  logic           pe,
  input  logic           reload,
  output logic [M_W-1:0] nxt_m,
  output logic [A_W-1:0] nxt_a,
  output logic           act_pe
);

  localparam logic [N_W-1:0] RST_N = N_W'(RST_RATIO);

  logic [M_W-1:0] in_m;
  logic [A_W-1:0] in_a;
  logic           in_ok;

  assign in_m  = ratio[N_W-1:A_W];
  assign in_a  = ratio[A_W-1:0];
  assign in_ok = (in_m >= M_W'(mnd_pkg::MIN_M)) && (in_m >= M_W'(in_a));

  logic           pend_v;
  logic [M_W-1:0] pend_m, act_m;
  logic [A_W-1:0] pend_a, act_a;
  logic           pend_pe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_v  <= 1'b0;
      pend_m  <= '0;
      pend_a  <= '0;
      pend_pe <= 1'b0;
      act_m   <= RST_N[N_W-1:A_W];
      act_a   <= RST_N[A_W-1:0];
      act_pe  <= 1'b0;
    end else begin
      if (reload && pend_v) begin
        act_m  <= pend_m;
        act_a  <= pend_a;
        act_pe <= pend_pe;
        pend_v <= 1'b0;
      end
      // A request arriving with the reload waits for the next one;
      // a later request overwrites an earlier pending one.
      if (load && in_ok) begin
        pend_m  <= in_m;
        pend_a  <= in_a;
        pend_pe <= pe;
        pend_v  <= 1'b1;
      end
    end
  end

  // Counter load values presented at the reload edge
  assign nxt_m = pend_v ? pend_m : act_m;
  assign nxt_a = pend_v ? pend_a : act_a;

endmodule

// File: rtl/mnd_mod_core.sv
module mnd_mod_core #(
  parameter int unsigned M_W       = mnd_pkg::DEF_M_W,
  parameter int unsigned A_W       = mnd_pkg::DEF_A_W,
  parameter int unsigned RST_RATIO = mnd_pkg::DEF_RST_RATIO
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic [M_W-1:0] nxt_m,
  input  logic [A_W-1:0] nxt_a,
  output logic           reload,
  output logic           fpd,
  output logic           fpd_half,
  output logic           strobe
);

  localparam int unsigned N_W  = M_W + A_W;
  localparam int unsigned S_W  = A_W + 1;
  localparam logic [N_W-1:0] RST_N   = N_W'(RST_RATIO);
  localparam logic [S_W-1:0] LAST_LO = S_W'((1 << A_W) - 1);
  localparam logic [S_W-1:0] LAST_HI = S_W'(1 << A_W);

  logic [S_W-1:0] sub_cnt;
  logic [M_W-1:0] m_cnt;
  logic [A_W-1:0] a_cnt;
  logic           first_q, half_q, strobe_q;
  logic           mod_hi, sub_end, last_sub;

  assign mod_hi   = (a_cnt != '0);
  assign sub_end  = tick && (sub_cnt == (mod_hi ? LAST_HI : LAST_LO));
  assign last_sub = (m_cnt == M_W'(1));
  assign reload   = sub_end && last_sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_cnt  <= '0;
      m_cnt    <= RST_N[N_W-1:A_W];
      a_cnt    <= RST_N[A_W-1:0];
      first_q  <= 1'b0;
      half_q   <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= reload;
      if (tick) begin
        if (sub_end) sub_cnt <= '0;
        else         sub_cnt <= sub_cnt + S_W'(1);
      end
      if (reload) begin
        m_cnt   <= nxt_m;
        a_cnt   <= nxt_a;
        first_q <= 1'b1;
        half_q  <= ~half_q;
      end else if (sub_end) begin
        m_cnt   <= m_cnt - M_W'(1);
        if (mod_hi) a_cnt <= a_cnt - A_W'(1);
        first_q <= 1'b0;
      end
    end
  end

  assign fpd      = first_q;
  assign fpd_half = half_q;
  assign strobe   = strobe_q;

endmodule

// File: rtl/mnd_divider.sv
module mnd_divider #(
  parameter int unsigned M_W          = mnd_pkg::DEF_M_W,
  parameter int unsigned A_W          = mnd_pkg::DEF_A_W,
  parameter int unsigned RST_RATIO    = mnd_pkg::DEF_RST_RATIO,
  parameter bit          HAS_PRESCALE = 1'b1,
  localparam int unsigned N_W         = M_W + A_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] ratio,
  input  logic           pe,
  input  logic           load,
  output logic           fpd,
  output logic           fpd_half,
  output logic           strobe
);

  logic           tick, reload, act_pe;
  logic [M_W-1:0] nxt_m;
  logic [A_W-1:0] nxt_a;

  mnd_tick_gen #(.HAS_PRESCALE(HAS_PRESCALE)) u_tick (
    .clk(clk), .rst(rst), .pe_act(act_pe), .realign(reload), .tick(tick)
  );

  mnd_ratio_hold #(.M_W(M_W), .A_W(A_W), .RST_RATIO(RST_RATIO)) u_hold (
    .clk(clk), .rst(rst), .load(load), .ratio(ratio), .pe(pe),
    .reload(reload), .nxt_m(nxt_m), .nxt_a(nxt_a), .act_pe(act_pe)
  );

  mnd_mod_core #(.M_W(M_W), .A_W(A_W), .RST_RATIO(RST_RATIO)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .nxt_m(nxt_m), .nxt_a(nxt_a),
    .reload(reload), .fpd(fpd), .fpd_half(fpd_half), .strobe(strobe)
  );

endmodule

// File: rtl/mnd_divider_chk.sv
module mnd_divider_chk (
  input logic clk,
  input logic rst,
  input logic fpd,
  input logic fpd_half,
  input logic strobe
);

  logic [19:0] gap;

  always_ff @(posedge clk) begin
    if (rst || strobe)  gap <= '0;
    else if (gap != '1) gap <= gap + 20'd1;
  end

  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

  assert_strobe_with_rise_R5: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (fpd && !$past(fpd)));

  assert_rise_needs_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(fpd) |-> strobe);

  assert_half_toggle_R6: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (fpd_half != $past(fpd_half)));

  assert_half_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !strobe |-> $stable(fpd_half));

  // Accepted ratios have M >= 2, so reloads are at least 32 clocks apart
  assert_min_period_R9: assert property (@(posedge clk) disable iff (rst)
    strobe |-> (gap >= 20'd31));

endmodule

bind mnd_divider mnd_divider_chk u_chk (
  .clk(clk), .rst(rst), .fpd(fpd), .fpd_half(fpd_half), .strobe(strobe)
);

// File: tb/sim_mnd_divider.sv
module sim_mnd_divider;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] ratio_i = '0;
  logic        pe_i = 1'b0;
  logic        load_i = 1'b0;
  logic        fpd, fpd_half, strobe;

  int checks = 0;
  int errors = 0;
  int cur_period = 0;
  int meas_period, meas_high;
  bit meas_half_ok;

  always #2 clk = ~clk;

  mnd_divider u0 (
    .clk(clk), .rst(rst), .ratio(ratio_i), .pe(pe_i), .load(load_i),
    .fpd(fpd), .fpd_half(fpd_half), .strobe(strobe)
  );

  function automatic int exp_period(input int r, input bit p);
    return p ? 2 * r : r;
  endfunction

  function automatic int exp_high(input int r, input bit p);
    int t;
    t = ((r % 16) != 0) ? 17 : 16;
    return p ? 2 * t : t;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Counts clocks up to and including the next strobe
  task automatic wait_strobe(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!strobe);
  endtask

  // Called at a strobe negedge; measures the cycle that starts there
  task automatic measure();
    bit h0;
    h0 = fpd_half;
    meas_period = 0;
    meas_high = fpd ? 1 : 0;
    forever begin
      @(negedge clk);
      meas_period++;
      if (strobe) break;
      if (fpd) meas_high++;
    end
    meas_half_ok = (fpd_half != h0);
  endtask

  task automatic submit(input int r, input bit p);
    ratio_i = 17'(r);
    pe_i = p;
    load_i = 1'b1;
    @(negedge clk);
    load_i = 1'b0;
  endtask

  // Called at a strobe negedge. Submits a request, checks the running
  // cycle is unchanged, then measures the following cycle.
  task automatic run(input int r, input bit p, input int er, input bit ep,
                     input string tag);
    int n;
    submit(r, p);
    wait_strobe(n);
    chk((n + 1) == cur_period, "R7 current cycle kept", n + 1, cur_period);
    measure();
    chk(meas_period == exp_period(er, ep), tag, meas_period, exp_period(er, ep));
    chk(meas_high == exp_high(er, ep), "R4 first sub-cycle length", meas_high, exp_high(er, ep));
    chk(meas_half_ok, "R6 fpd_half toggle", int'(meas_half_ok), 1);
    cur_period = meas_period;
  endtask

  initial begin : watchdog
    repeat (199000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    int r;
    bit p;
    void'($urandom(32'd1234));

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(!fpd && !fpd_half && !strobe, "R1 outputs low in reset",
        int'({fpd, fpd_half, strobe}), 0);
    rst = 1'b0;
    wait_strobe(n);
    chk(n == 240, "R1 first strobe after reset", n, 240);
    measure();
    chk(meas_period == 240, "R1 R2 reset ratio period", meas_period, 240);
    chk(meas_high == 16, "R4 first sub-cycle A=0", meas_high, 16);
    cur_period = meas_period;

    // Directed ratios, both prescaler settings
    run(241, 1'b0, 241, 1'b0, "R2 period 241");
    run(255, 1'b0, 255, 1'b0, "R2 period 255");
    run(240, 1'b1, 240, 1'b1, "R3 period 2x240");
    run(4095, 1'b1, 4095, 1'b1, "R3 period 2x4095");
    run(256, 1'b0, 256, 1'b0, "R2 R7 prescaler off again");

    // R9: rejected requests leave the ratio unchanged
    run(17, 1'b1, 256, 1'b0, "R9 M below 2 ignored");
    run(15, 1'b0, 256, 1'b0, "R9 M zero ignored");
    run(53, 1'b1, 256, 1'b0, "R9 M below A ignored");

    // R8: last of two requests wins
    submit(300, 1'b0);
    submit(700, 1'b1);
    wait_strobe(n);
    chk((n + 2) == cur_period, "R7 R8 current cycle kept", n + 2, cur_period);
    measure();
    chk(meas_period == 1400, "R8 last request applied", meas_period, 1400);
    cur_period = meas_period;

    // Random ratios with random prescaler setting
    for (int i = 0; i < 6; i++) begin
      r = $urandom_range(900, 240);
      p = 1'($urandom_range(1, 0));
      run(r, p, r, p, p ? "R3 random ratio" : "R2 random ratio");
    end

    // Upper end of the direct range
    run(131071, 1'b0, 131071, 1'b0, "R2 period 131071");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule